// File: doc/BRIEF.md
# Threshold Interrupt Controller

This block watches a stream of measurement results and turns them into two status flags and one interrupt line. A result arrives with a one-cycle conversion-done strobe. The block compares it against a programmable upper and lower bound. A fault filter demands a run of consecutive out-of-range results before anything changes. The flags and an internal threshold state then update according to the reporting mode. In the hysteresis mode they track which side the signal last crossed to. In the window mode they capture any excursion and hold it until software reads the status register.

The interrupt line can show the threshold state. It can also give a fixed-width pulse after every conversion, or after every fourth conversion, which marks a full four-entry result buffer elsewhere in the chip. The line has a selectable active level. It leaves the block as a level plus a pull-low enable, so that a pad can wire-AND several sources on one shared line.

Top module: `thresh_irq_top`

## Requirements
- R1: After reset, both flags are 0, the threshold state is inactive, and the interrupt level is the inactive level (`irqLevel` = `!polHigh`).
- R2: Comparisons are unsigned and strict. A result is a high fault only when it is greater than `thrHigh`, and a low fault only when it is less than `thrLow`. A result equal to either bound is not a fault.
- R3: With `latchMode`=0 (hysteresis), a qualified high fault sets `flagHigh`=1, `flagLow`=0 and the threshold state active. A qualified low fault sets `flagHigh`=0, `flagLow`=1 and the state inactive. An in-range result holds all three. The updated values are visible in the cycle after the one in which `convDone` is sampled.
- R4: With `latchMode`=0, a pulse on `statusRd` has no effect on the flags or the interrupt.
- R5: With `latchMode`=1 (window), a qualified high fault sets `flagHigh` and a qualified low fault sets `flagLow`. Either one makes the threshold state active. In-range results clear nothing.
- R6: With `latchMode`=1, a `statusRd` pulse clears both flags and the threshold state. If a qualified fault is sampled in the same cycle, that fault's flag and the state end up set.
- R7: `faultSel` values 0, 1, 2 and 3 need 1, 2, 4 and 8 consecutive faults of the same kind. The high and low conditions each have their own count, and a conversion that does not meet a condition restarts that condition's count.
- R8: With `outSel` equal to 0 or 2, the interrupt shows the threshold state.
- R9: With `outSel`=1, each conversion starts an active pulse of `PULSE_CYC` cycles, beginning in the cycle after `convDone`. A new conversion during a pulse restarts it.
- R10: With `outSel`=3, a `PULSE_CYC`-cycle pulse follows every fourth conversion. Counting restarts whenever `outSel` changes value.
- R11: The flags follow R3 to R7 whatever the `outSel` value.
- R12: `irqLevel` equals the active condition when `polHigh`=1 and its inverse when `polHigh`=0. `irqPullLow` is 1 exactly when `irqLevel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| convDone | input | 1 | One-cycle strobe: `measVal` holds a new result |
| measVal | input | DATA_W | Measurement result |
| thrHigh | input | DATA_W | Upper bound |
| thrLow | input | DATA_W | Lower bound |
| latchMode | input | 1 | 0 hysteresis reporting, 1 latched window reporting |
| faultSel | input | 2 | Consecutive-fault filter select (1, 2, 4, 8) |
| outSel | input | 2 | Interrupt function: 0/2 threshold, 1 per conversion, 3 every fourth |
| polHigh | input | 1 | 1: interrupt active high, 0: active low |
| statusRd | input | 1 | One-cycle strobe: status register read |
| flagHigh | output | 1 | High-side flag |
| flagLow | output | 1 | Low-side flag |
| irqLevel | output | 1 | Polarity-adjusted interrupt level |
| irqPullLow | output | 1 | Open-drain pull-low enable |

## Verification
The bench builds the block with `DATA_W`=12 and `PULSE_CYC`=3. The short pulse lets every cycle of a pulse be checked, including its end and a restart, within a few clock edges. The narrow word keeps the thresholds and the equality corners easy to state. The two-bit filter and the every-fourth counter are fixed-size, so every filter depth and the counter restart on an `outSel` change are reached directly with these values.

// File: rtl/thresh_irq_pkg.sv
package thresh_irq_pkg;

  typedef enum logic [1:0] {
    OUT_THRESH = 2'd0,
    OUT_EACH   = 2'd1,
    OUT_ALT    = 2'd2,
    OUT_FOURTH = 2'd3
  } outFunc_e;

  localparam int FILT_MAX = 8;
  localparam int FILT_W   = $clog2(FILT_MAX + 1);

  typedef struct packed {
    logic              evalEn;
    logic              clearEn;
    logic              latchWin;
    logic [FILT_W-1:0] needCnt;
  } ctlStrobe_t;

  function automatic logic [FILT_W-1:0] decodeNeed(input logic [1:0] sel);
    return FILT_W'(1) << sel;
  endfunction

endpackage

// File: rtl/thresh_irq_filter.sv
module thresh_irq_filter
  import thresh_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              evalEn,
  input  logic              hit,
  input  logic [FILT_W-1:0] needCnt,
  output logic              qualify
);

  logic [FILT_W-1:0] runQ;
  logic [FILT_W-1:0] runNext;

  always_comb begin
    runNext = (runQ == FILT_W'(FILT_MAX)) ? runQ : runQ + FILT_W'(1);
    qualify = evalEn && hit && (runNext >= needCnt);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ <= '0;
    end else if (evalEn) begin
      runQ <= hit ? runNext : '0;
    end
  end

endmodule

// File: rtl/thresh_irq_dp.sv
module thresh_irq_dp
  import thresh_irq_pkg::*;
#(
  parameter int DATA_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [DATA_W-1:0] measVal,
  input  logic [DATA_W-1:0] thrHigh,
  input  logic [DATA_W-1:0] thrLow,
  output logic              flagHigh,
  output logic              flagLow,
  output logic              threshActive
);

  localparam int NUM_COND = 2;
  localparam int IDX_HI   = 0;
  localparam int IDX_LO   = 1;

  logic [NUM_COND-1:0] condHit;
  logic [NUM_COND-1:0] condQual;

  assign condHit[IDX_HI] = measVal > thrHigh;
  assign condHit[IDX_LO] = measVal < thrLow;

  for (genvar g = 0; g < NUM_COND; g++) begin : gFilt
    thresh_irq_filter uFilt (
      .clk     (clk),
      .rstN    (rstN),
      .evalEn  (strobe.evalEn),
      .hit     (condHit[g]),
      .needCnt (strobe.needCnt),
      .qualify (condQual[g])
    );
  end

  logic flagHighQ, flagLowQ, stateQ;
  logic flagHighD, flagLowD, stateD;

  always_comb begin
    flagHighD = flagHighQ;
    flagLowD  = flagLowQ;
    stateD    = stateQ;
    if (strobe.latchWin) begin
      if (strobe.clearEn) begin
        flagHighD = 1'b0;
        flagLowD  = 1'b0;
        stateD    = 1'b0;
      end
      if (condQual[IDX_HI]) flagHighD = 1'b1;
      if (condQual[IDX_LO]) flagLowD  = 1'b1;
      if (|condQual)        stateD    = 1'b1;
    end else if (condQual[IDX_HI]) begin
      flagHighD = 1'b1;
      flagLowD  = 1'b0;
      stateD    = 1'b1;
    end else if (condQual[IDX_LO]) begin
      flagHighD = 1'b0;
      flagLowD  = 1'b1;
      stateD    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagHighQ <= 1'b0;
      flagLowQ  <= 1'b0;
      stateQ    <= 1'b0;
    end else begin
      flagHighQ <= flagHighD;
      flagLowQ  <= flagLowD;
      stateQ    <= stateD;
    end
  end

  assign flagHigh     = flagHighQ;
  assign flagLow      = flagLowQ;
  assign threshActive = stateQ;

endmodule

// File: rtl/thresh_irq_ctl.sv
module thresh_irq_ctl
  import thresh_irq_pkg::*;
#(
  parameter int PULSE_CYC = 50
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       convDone,
  input  logic       statusRd,
  input  logic       latchMode,
  input  logic [1:0] faultSel,
  input  logic [1:0] outSel,
  input  logic       polHigh,
  input  logic       threshActive,
  output ctlStrobe_t strobe,
  output logic       irqLevel,
  output logic       irqPullLow
);

  localparam int PW_W   = $clog2(PULSE_CYC + 1);
  localparam int QUAD_N = 4;
  localparam int QUAD_W = $clog2(QUAD_N);

  outFunc_e          outFunc;
  logic [1:0]        outSelQ;
  logic              selChanged;
  logic [QUAD_W-1:0] quadCntQ;
  logic [PW_W-1:0]   pulseTmrQ;
  logic              fire;
  logic              active;

  assign outFunc    = outFunc_e'(outSel);
  assign selChanged = outSel != outSelQ;

  always_comb begin
    strobe.evalEn   = convDone;
    strobe.clearEn  = statusRd && latchMode;
    strobe.latchWin = latchMode;
    strobe.needCnt  = decodeNeed(faultSel);
  end

  always_comb begin
    fire = 1'b0;
    if (convDone) begin
      if (outFunc == OUT_EACH) begin
        fire = 1'b1;
      end else if (outFunc == OUT_FOURTH && !selChanged &&
                   quadCntQ == QUAD_W'(QUAD_N - 1)) begin
        fire = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outSelQ   <= 2'd0;
      quadCntQ  <= '0;
      pulseTmrQ <= '0;
    end else begin
      outSelQ <= outSel;
      if (selChanged) begin
        quadCntQ <= '0;
      end else if (convDone && outFunc == OUT_FOURTH) begin
        quadCntQ <= quadCntQ + QUAD_W'(1);
      end
      if (fire) begin
        pulseTmrQ <= PW_W'(PULSE_CYC);
      end else if (pulseTmrQ != '0) begin
        pulseTmrQ <= pulseTmrQ - PW_W'(1);
      end
    end
  end

  always_comb begin
    case (outFunc)
      OUT_EACH, OUT_FOURTH: active = pulseTmrQ != '0;
      default:              active = threshActive;
    endcase
    irqLevel   = polHigh ? active : !active;
    irqPullLow = !irqLevel;
  end

endmodule

// File: rtl/thresh_irq_top.sv
module thresh_irq_top
  import thresh_irq_pkg::*;
#(
  parameter int DATA_W    = 20,
  parameter int PULSE_CYC = 50
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              convDone,
  input  logic [DATA_W-1:0] measVal,
  input  logic [DATA_W-1:0] thrHigh,
  input  logic [DATA_W-1:0] thrLow,
  input  logic              latchMode,
  input  logic [1:0]        faultSel,
  input  logic [1:0]        outSel,
  input  logic              polHigh,
  input  logic              statusRd,
  output logic              flagHigh,
  output logic              flagLow,
  output logic              irqLevel,
  output logic              irqPullLow
);

  ctlStrobe_t strobe;
  logic       threshActive;

  thresh_irq_ctl #(.PULSE_CYC(PULSE_CYC)) uCtl (
    .clk          (clk),
    .rstN         (rstN),
    .convDone     (convDone),
    .statusRd     (statusRd),
    .latchMode    (latchMode),
    .faultSel     (faultSel),
    .outSel       (outSel),
    .polHigh      (polHigh),
    .threshActive (threshActive),
    .strobe       (strobe),
    .irqLevel     (irqLevel),
    .irqPullLow   (irqPullLow)
  );

  thresh_irq_dp #(.DATA_W(DATA_W)) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .measVal      (measVal),
    .thrHigh      (thrHigh),
    .thrLow       (thrLow),
    .flagHigh     (flagHigh),
    .flagLow      (flagLow),
    .threshActive (threshActive)
  );

endmodule

// File: rtl/thresh_irq_chk.sv
module thresh_irq_chk #(
  parameter int DATA_W = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic              convDone,
  input logic [DATA_W-1:0] measVal,
  input logic [DATA_W-1:0] thrHigh,
  input logic              latchMode,
  input logic [1:0]        faultSel,
  input logic [1:0]        outSel,
  input logic              polHigh,
  input logic              statusRd,
  input logic              flagHigh,
  input logic              flagLow,
  input logic              irqLevel
);

  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !convDone && !(statusRd && latchMode) |=> $stable(flagHigh) && $stable(flagLow)); // R4

  AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    latchMode && statusRd && !convDone |=> !flagHigh && !flagLow); // R6

  AST_WINDOW_SET: assert property (@(posedge clk) disable iff (!rstN)
    latchMode && convDone && faultSel == 2'd0 && measVal > thrHigh |=> flagHigh); // R5

  AST_HYST_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !latchMode && convDone && faultSel == 2'd0 && measVal > thrHigh |=> flagHigh && !flagLow); // R3

  AST_EACH_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    convDone && outSel == 2'd1 |=> (outSel != 2'd1) || (irqLevel == polHigh)); // R9

endmodule

bind thresh_irq_top thresh_irq_chk #(.DATA_W(DATA_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .convDone  (convDone),
  .measVal   (measVal),
  .thrHigh   (thrHigh),
  .latchMode (latchMode),
  .faultSel  (faultSel),
  .outSel    (outSel),
  .polHigh   (polHigh),
  .statusRd  (statusRd),
  .flagHigh  (flagHigh),
  .flagLow   (flagLow),
  .irqLevel  (irqLevel)
);

// File: tb/sim_thresh_irq_top.sv
module sim_thresh_irq_top;

  localparam int DW = 12;
  localparam int PW = 3;
  localparam logic [DW-1:0] HI  = 12'd200;
  localparam logic [DW-1:0] LO  = 12'd100;
  localparam logic [DW-1:0] ABV = 12'd300;
  localparam logic [DW-1:0] BLW = 12'd50;
  localparam logic [DW-1:0] MID = 12'd150;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic convDone = 1'b0;
  logic [DW-1:0] measVal = '0;
  logic [DW-1:0] thrHigh = HI;
  logic [DW-1:0] thrLow = LO;
  logic latchMode = 1'b0;
  logic [1:0] faultSel = 2'd0;
  logic [1:0] outSel = 2'd0;
  logic polHigh = 1'b1;
  logic statusRd = 1'b0;
  logic flagHigh, flagLow, irqLevel, irqPullLow;

  int nTests = 0;
  int nFail = 0;

  always #10 clk = ~clk;

  thresh_irq_top #(.DATA_W(DW), .PULSE_CYC(PW)) u0 (
    .clk(clk), .rstN(rstN), .convDone(convDone), .measVal(measVal),
    .thrHigh(thrHigh), .thrLow(thrLow), .latchMode(latchMode),
    .faultSel(faultSel), .outSel(outSel), .polHigh(polHigh),
    .statusRd(statusRd), .flagHigh(flagHigh), .flagLow(flagLow),
    .irqLevel(irqLevel), .irqPullLow(irqPullLow)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chkOut(input string tag, input logic h, input logic l, input logic irq);
    chk({tag, " flagHigh"}, 32'(flagHigh), 32'(h));
    chk({tag, " flagLow"}, 32'(flagLow), 32'(l));
    chk({tag, " irqLevel"}, 32'(irqLevel), 32'(irq));
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; convDone = 1'b0; statusRd = 1'b0; latchMode = 1'b0;
    faultSel = 2'd0; outSel = 2'd0; polHigh = 1'b1; measVal = '0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic conv(input logic [DW-1:0] v);
    @(negedge clk);
    measVal = v; convDone = 1'b1;
    @(negedge clk);
    convDone = 1'b0;
  endtask

  task automatic readStatus();
    @(negedge clk);
    statusRd = 1'b1;
    @(negedge clk);
    statusRd = 1'b0;
  endtask

  task automatic tReset();
    doReset();
    chkOut("R1 reset", 1'b0, 1'b0, 1'b0);
    chk("R1 reset pullLow", 32'(irqPullLow), 32'd1);
  endtask

  task automatic tHysteresis();
    doReset();
    conv(ABV); chkOut("R3 above", 1'b1, 1'b0, 1'b1);
    conv(MID); chkOut("R3 between holds", 1'b1, 1'b0, 1'b1);
    conv(LO);  chkOut("R2 equal low no fault", 1'b1, 1'b0, 1'b1);
    conv(BLW); chkOut("R3 below", 1'b0, 1'b1, 1'b0);
    conv(HI);  chkOut("R2 equal high no fault", 1'b0, 1'b1, 1'b0);
    conv(12'd201); chkOut("R2 one above high", 1'b1, 1'b0, 1'b1);
    readStatus(); chkOut("R4 read ignored", 1'b1, 1'b0, 1'b1);
  endtask

  task automatic tWindow();
    doReset();
    latchMode = 1'b1;
    conv(ABV); chkOut("R5 high set", 1'b1, 1'b0, 1'b1);
    conv(MID); chkOut("R5 held in range", 1'b1, 1'b0, 1'b1);
    conv(BLW); chkOut("R5 both set", 1'b1, 1'b1, 1'b1);
    readStatus(); chkOut("R6 read clears", 1'b0, 1'b0, 1'b0);
    conv(MID); chkOut("R6 stays clear", 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    measVal = ABV; convDone = 1'b1; statusRd = 1'b1;
    @(negedge clk);
    convDone = 1'b0; statusRd = 1'b0;
    chkOut("R6 fault wins over read", 1'b1, 1'b0, 1'b1);
  endtask

  task automatic tFilter();
    doReset();
    faultSel = 2'd2;
    for (int i = 0; i < 3; i++) begin
      conv(ABV); chkOut("R7 four needed, not yet", 1'b0, 1'b0, 1'b0);
    end
    conv(ABV); chkOut("R7 fourth fault", 1'b1, 1'b0, 1'b1);
    faultSel = 2'd1;
    conv(BLW); chkOut("R7 one low of two", 1'b1, 1'b0, 1'b1);
    conv(MID); chkOut("R7 run broken", 1'b1, 1'b0, 1'b1);
    conv(BLW); chkOut("R7 restart count", 1'b1, 1'b0, 1'b1);
    conv(BLW); chkOut("R7 second low", 1'b0, 1'b1, 1'b0);
    faultSel = 2'd3;
    for (int i = 0; i < 7; i++) conv(ABV);
    chkOut("R7 seven of eight", 1'b0, 1'b1, 1'b0);
    conv(ABV); chkOut("R7 eighth fault", 1'b1, 1'b0, 1'b1);
  endtask

  task automatic tAltSel();
    doReset();
    outSel = 2'd2;
    conv(ABV); chk("R8 sel2 follows state", 32'(irqLevel), 32'd1);
    conv(BLW); chk("R8 sel2 follows state low", 32'(irqLevel), 32'd0);
  endtask

  task automatic tEach();
    doReset();
    outSel = 2'd1;
    @(negedge clk);
    chk("R9 idle", 32'(irqLevel), 32'd0);
    conv(ABV);
    chk("R9 pulse c1", 32'(irqLevel), 32'd1);
    chk("R11 flag in pulse mode", 32'(flagHigh), 32'd1);
    @(negedge clk); chk("R9 pulse c2", 32'(irqLevel), 32'd1);
    @(negedge clk); chk("R9 pulse c3", 32'(irqLevel), 32'd1);
    @(negedge clk); chk("R9 pulse ends", 32'(irqLevel), 32'd0);
    conv(MID);
    @(negedge clk);
    conv(MID);
    @(negedge clk); chk("R9 restart c2", 32'(irqLevel), 32'd1);
    @(negedge clk); chk("R9 restart c3", 32'(irqLevel), 32'd1);
    @(negedge clk); chk("R9 restart ends", 32'(irqLevel), 32'd0);
  endtask

  task automatic tFourth();
    doReset();
    outSel = 2'd3;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      conv(MID); chk("R10 no pulse before fourth", 32'(irqLevel), 32'd0);
    end
    conv(BLW); chk("R10 pulse on fourth", 32'(irqLevel), 32'd1);
    chk("R11 flag in fourth mode", 32'(flagLow), 32'd1);
    repeat (3) @(negedge clk);
    chk("R10 pulse ends", 32'(irqLevel), 32'd0);
    conv(MID); conv(MID);
    outSel = 2'd0;
    @(negedge clk);
    outSel = 2'd3;
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      conv(MID); chk("R10 count restarted", 32'(irqLevel), 32'd0);
    end
    conv(MID); chk("R10 pulse after restart", 32'(irqLevel), 32'd1);
  endtask

  task automatic tPolarity();
    doReset();
    conv(ABV);
    chk("R12 active high level", 32'(irqLevel), 32'd1);
    chk("R12 active high pull", 32'(irqPullLow), 32'd0);
    polHigh = 1'b0;
    @(negedge clk);
    chk("R12 active low level", 32'(irqLevel), 32'd0);
    chk("R12 active low pull", 32'(irqPullLow), 32'd1);
    conv(BLW);
    chk("R12 inactive low-pol level", 32'(irqLevel), 32'd1);
    chk("R12 inactive low-pol pull", 32'(irqPullLow), 32'd0);
  endtask

  initial begin
    #(20 * 100000);
    nFail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    tReset();
    tHysteresis();
    tWindow();
    tFilter();
    tAltSel();
    tEach();
    tFourth();
    tPolarity();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule